// File: doc/BRIEF.md
# Sensor Peripheral Clock and Interrupt Register Front End

This block is the register-side front end of a sensor conversion peripheral. A 16-bit register bus reads and writes four words. From these words the block does four things:

- It chooses one of four clock-enable sources.
- It divides the chosen source by a ratio that depends on which source it is.
- It stops the resulting module clock enable while a debug halt is active, unless a debug-run bit allows it to keep running.
- It holds an 8-bit conversion-time setting for the conversion core.

The block also holds a conversion-complete interrupt flag and its enable. The core's completion pulse sets the flag. A read of the result word clears it. An interrupt request is raised while the flag and the enable are both set.

The design uses one clock only. Each of the four sources arrives as a clock-enable strobe on `src_ce`. The divided output is a one-cycle strobe on `mod_ce`.

Register words (selected by `bus_addr`):

| Address | Contents |
|---|---|
| 0 | Clock control: source select in bits 1–0, divide select in bits 5–4, debug-run in bit 8. All other bits read 0. |
| 1 | Conversion time in bits 7–0. All other bits read 0. |
| 2 | Bit 0 is the interrupt flag (read only). Bit 1 is the interrupt enable (read/write). |
| 3 | Result word, passed through from `result_data`. |

Top module: `sensclk_regs`

## Requirements
- R1: After reset, words 0, 1 and 2 read 0x0000, and `irq`, `mod_ce` and `conv_time` are 0.
- R2: Word 0 stores bits 1–0, 5–4 and 8. Writing 0xFFFF reads back 0x0133.
- R3: A write to word 0 while `mod_en` is 1 leaves word 0 unchanged.
- R4: With source 0 or 2 selected, divide select values 0, 1, 2 and 3 give one `mod_ce` pulse per 1, 2, 4 and 8 counted source strobes.
- R5: With source 1 or 3 selected, every counted source strobe gives a `mod_ce` pulse, whatever the divide select value.
- R6: While `dbg_mode` is 1 and debug-run is 0, `mod_ce` stays 0 and no source strobe is counted.
- R7: Word 1 stores bits 7–0, drives them on `conv_time`, and reads 0 in bits 15–8.
- R8: A `conv_done` pulse sets the flag from the next cycle on. A read of word 3 clears the flag from the next cycle on. A write to word 3 does not clear it.
- R9: `irq` is 1 exactly while the flag and the enable (word 2 bit 1) are both 1.
- R10: When `conv_done` and a read of word 3 happen in the same cycle, the flag ends up set.
- R11: An accepted write to word 0 restarts the divider count. The first pulse after the write comes at the full ratio of counted strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the word at `bus_addr`, combinational |
| src_ce | input | 4 | Clock-enable strobes of the four sources, indexed by source select |
| mod_en | input | 1 | Module enabled; while 1, clock control writes are refused |
| dbg_mode | input | 1 | Debug halt active |
| conv_done | input | 1 | One-cycle conversion-complete pulse from the core |
| result_data | input | 16 | Conversion result shown at word 3 |
| mod_ce | output | 1 | Divided, gated module clock-enable strobe |
| conv_time | output | 8 | Conversion-time setting |
| irq | output | 1 | Interrupt request |

## Verification
`bus_rdata` and `mod_ce` are combinational. The bench checks them in the same cycle as the inputs that drive them, 5 ns after those inputs change at the falling edge. Register effects (writes, flag set and clear) become visible one rising edge later, so the bench checks them at the following falling edge. The divider model advances once per cycle from the strobe the bench has just driven, which keeps its count aligned with the design's count register.

// File: rtl/sensclk_regs.sv
module sensclk_regs #(
  parameter int TIMW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [3:0]  src_ce,
  input  logic        mod_en,
  input  logic        dbg_mode,
  input  logic        conv_done,
  input  logic [15:0] result_data,
  output logic        mod_ce,
  output logic [TIMW-1:0] conv_time,
  output logic        irq
);
  localparam int PADW = 16 - TIMW;

  logic [1:0] src_q, div_q;
  logic       dbgrun_q, flag_q, ien_q;
  logic [TIMW-1:0] tim_q;
  logic [2:0] cnt_q, limit;
  logic       wr_clk, sel_ce, tick, rd_res;

  assign wr_clk = bus_wr && bus_addr == 2'd0 && !mod_en;
  assign rd_res = bus_rd && bus_addr == 2'd3;
  assign sel_ce = src_ce[src_q];
  assign tick   = sel_ce && (!dbg_mode || dbgrun_q);

  always_comb begin
    if (src_q[0]) limit = 3'd0;
    else begin
      case (div_q)
        2'd0:    limit = 3'd0;
        2'd1:    limit = 3'd1;
        2'd2:    limit = 3'd3;
        default: limit = 3'd7;
      endcase
    end
  end

  assign mod_ce = tick && cnt_q == limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      div_q    <= '0;
      dbgrun_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (wr_clk) begin
        src_q    <= bus_wdata[1:0];
        div_q    <= bus_wdata[5:4];
        dbgrun_q <= bus_wdata[8];
        cnt_q    <= '0;
      end else if (tick) begin
        cnt_q <= (cnt_q == limit) ? 3'd0 : cnt_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q  <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == 2'd1) tim_q <= bus_wdata[TIMW-1:0];
      if (bus_wr && bus_addr == 2'd2) ien_q <= bus_wdata[1];
      if (conv_done)   flag_q <= 1'b1;
      else if (rd_res) flag_q <= 1'b0;
    end
  end

  assign conv_time = tim_q;
  assign irq       = flag_q && ien_q;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {7'd0, dbgrun_q, 2'd0, div_q, 2'd0, src_q};
      2'd1:    bus_rdata = {{PADW{1'b0}}, tim_q};
      2'd2:    bus_rdata = {14'd0, ien_q, flag_q};
      default: bus_rdata = result_data;
    endcase
  end
endmodule

// File: rtl/sensclk_regs_chk.sv
module sensclk_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       mod_en,
  input logic       dbg_mode,
  input logic       conv_done,
  input logic [3:0] src_ce,
  input logic       mod_ce,
  input logic       irq,
  input logic [1:0] src_q,
  input logic [1:0] div_q,
  input logic       dbgrun_q,
  input logic       flag_q,
  input logic       ien_q
);
  p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && bus_wr && bus_addr == 2'd0) |=> ($stable(src_q) && $stable(div_q) && $stable(dbgrun_q)));

  p_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q[0] && src_ce[src_q] && (!dbg_mode || dbgrun_q)) |-> mod_ce);

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !dbgrun_q) |-> !mod_ce);

  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> flag_q);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3 && !conv_done) |=> !flag_q);

  p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && bus_rd && bus_addr == 2'd3) |=> flag_q);

  p_irq_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q && flag_q));
endmodule

bind sensclk_regs sensclk_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .mod_en(mod_en), .dbg_mode(dbg_mode), .conv_done(conv_done), .src_ce(src_ce),
  .mod_ce(mod_ce), .irq(irq), .src_q(src_q), .div_q(div_q), .dbgrun_q(dbgrun_q),
  .flag_q(flag_q), .ien_q(ien_q)
);

// File: tb/tb_sensclk_regs.sv
`timescale 1ns/1ps
module tb_sensclk_regs;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata, result_data = 16'h5A3C;
  logic [3:0] src_ce = 0;
  logic mod_en = 0, dbg_mode = 0, conv_done = 0;
  logic mod_ce, irq;
  logic [7:0] conv_time;

  int checks = 0, errors = 0;
  bit finished = 0;

  sensclk_regs dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ratio(input int src, input int dv);
    if (src == 1 || src == 3) return 1;
    return 1 << dv;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #5; d = bus_rdata;
  endtask

  int mcnt;
  int msrc, mdiv;
  bit mdbgrun;

  task automatic div_run(input int n, input string req, input bit rnd, inout int bad);
    for (int i = 0; i < n; i++) begin
      logic [3:0] ce;
      bit exp, tk;
      int lim;
      @(negedge clk);
      ce = rnd ? 4'($urandom) : 4'hF;
      src_ce = ce;
      dbg_mode = rnd ? ($urandom % 3 == 0) : 1'b0;
      #5;
      lim = ratio(msrc, mdiv) - 1;
      tk = ce[msrc] && (!dbg_mode || mdbgrun);
      exp = tk && mcnt == lim;
      if (mod_ce !== exp) bad++;
      if (tk) mcnt = (mcnt == lim) ? 0 : mcnt + 1;
    end
    @(negedge clk);
    src_ce = 0; dbg_mode = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int bad;
    bit mflag, mien;
    void'($urandom(32'd2024));
    #35 rst_n = 1;
    @(negedge clk);
    peek(0, d); chk("R1 word0", d, 0);
    peek(1, d); chk("R1 word1", d, 0);
    peek(2, d); chk("R1 word2", d, 0);
    chk("R1 irq/mod_ce/conv_time", {irq, mod_ce, conv_time}, 0);

    wr(0, 16'hFFFF);
    peek(0, d); chk("R2 field layout", d, 16'h0133);
    mod_en = 1;
    wr(0, 16'h0000);
    peek(0, d); chk("R3 locked write ignored", d, 16'h0133);
    mod_en = 0;
    wr(0, 16'h0000);
    peek(0, d); chk("R3 unlocked write accepted", d, 16'h0000);

    wr(1, 16'hABCD);
    peek(1, d); chk("R7 timing readback", d, 16'h00CD);
    chk("R7 conv_time", conv_time, 8'hCD);

    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 4; v++) begin
        msrc = s; mdiv = v; mdbgrun = $urandom % 2; mcnt = 0;
        wr(0, 16'(s | (v << 4) | (int'(mdbgrun) << 8)));
        bad = 0;
        div_run(80, "", 1, bad);
        if (s == 1 || s == 3) chk("R5 undivided source", bad, 0);
        else chk("R4 fast source ratio", bad, 0);
      end

    msrc = 0; mdiv = 2; mdbgrun = 0; mcnt = 0;
    wr(0, 16'h0020);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      src_ce = 4'hF; dbg_mode = 1; #5;
      if (mod_ce !== 1'b0) bad++;
    end
    src_ce = 0; dbg_mode = 0;
    chk("R6 debug halt gating", bad, 0);
    bad = 0;
    div_run(4, "", 0, bad);
    chk("R6 count frozen during halt", bad, 0);

    msrc = 0; mdiv = 3; mdbgrun = 0; mcnt = 0;
    wr(0, 16'h0030);
    bad = 0;
    div_run(5, "", 0, bad);
    wr(0, 16'h0030); mcnt = 0;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); src_ce = 4'hF; #5;
      if (mod_ce !== (i == 7)) bad++;
    end
    src_ce = 0;
    chk("R11 restart after write", bad, 0);

    wr(2, 16'h0002);
    @(negedge clk); conv_done = 1;
    @(negedge clk); conv_done = 0;
    peek(2, d); chk("R8 flag set", d, 16'h0003);
    chk("R9 irq with enable", irq, 1);
    wr(3, 16'h0000);
    peek(2, d); chk("R8 write to word3 no clear", d[0], 1);
    @(negedge clk); bus_addr = 3; bus_rd = 1; #5;
    chk("R8 result word readout", bus_rdata, 16'h5A3C);
    @(negedge clk); bus_rd = 0;
    peek(2, d); chk("R8 read clears flag", d[0], 0);
    chk("R9 irq low after clear", irq, 0);
    wr(2, 16'h0000);
    @(negedge clk); conv_done = 1;
    @(negedge clk); conv_done = 0; #5;
    chk("R9 irq masked", irq, 0);
    @(negedge clk); conv_done = 1; bus_rd = 1; bus_addr = 3;
    @(negedge clk); conv_done = 0; bus_rd = 0;
    peek(2, d); chk("R10 set wins", d[0], 1);

    mflag = 1; mien = 0; bad = 0;
    for (int i = 0; i < 300; i++) begin
      int op;
      @(negedge clk);
      op = $urandom % 4;
      conv_done = ($urandom % 4 == 0);
      bus_rd = (op == 1); bus_wr = (op == 2);
      bus_addr = (op == 2) ? 2'd2 : 2'd3;
      bus_wdata = 16'($urandom);
      #5;
      if (irq !== (mflag && mien)) bad++;
      if (conv_done) mflag = 1; else if (op == 1) mflag = 0;
      if (op == 2) mien = bus_wdata[1];
    end
    @(negedge clk); conv_done = 0; bus_rd = 0; bus_wr = 0;
    chk("R9 random irq tracking", bad, 0);
    peek(2, d); chk("R8 random flag state", d, {14'd0, mien, mflag});

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule